// File: doc/BRIEF.md
# Flash array scan and identification

This block walks a grid of flash banks ("floors") and the chip positions within each bank when the system starts up. It probes each position through a simple one-operation-at-a-time command port that a NAND sequencer serves. For every position it selects the bank and the chip, resets the chip, waits for ready, issues the read-ID command with a single zero address byte, and then reads back two bytes. The first byte is the manufacturer code and the second is the device code. A built-in identification table turns a recognised pair into a chip size exponent (log2 of the chip's byte capacity).

Probing moves through chips in ascending order within a bank and stops at the first position that gives no valid answer. The failure is sticky for the whole scan. Once one probe fails, no later bank is probed, so those banks count as empty. When the walk ends, the block holds the results on its outputs until the next start:

- the number of chips found;
- a packed table of {floor, chip} entries for the populated positions;
- the size exponent of the last recognised chip;
- the total capacity;
- a flag raised when nothing was found.

Top-level control is a four-state machine:

- `S_IDLE` moves to `S_LAUNCH` on `start`.
- `S_LAUNCH` moves to `S_WAIT` when it launches a probe. It stays in `S_LAUNCH` while it moves on to the next floor. It moves to `S_FINISH` when the scan has stopped or the last floor is exhausted.
- `S_WAIT` returns to `S_LAUNCH` when the probe completes.
- `S_FINISH` holds the results and returns to `S_LAUNCH` on a new `start`.

The probe engine has ten states, which step in this order:

- `P_IDLE` moves to `P_FLOOR` on launch.
- Each of `P_FLOOR`, `P_CHIP`, `P_RST`, `P_RDY`, `P_IDCMD`, `P_ADDR`, `P_RDMFR` and `P_RDDEV` moves to the next state on `op_done`.
- `P_RDDEV` leads to `P_DONE`.
- `P_DONE` returns to `P_IDLE` after one cycle.

Top module: `flscan_top`

## Requirements
- R1: Each probe issues exactly eight operations in this order, as `op_code`/`op_arg` pairs:
  - floor select (code 0, argument = floor index);
  - chip select (code 1, argument = chip index);
  - command 0xFF (code 2);
  - wait-ready (code 5, argument 0);
  - command 0x90 (code 2);
  - address 0x00 (code 3);
  - read (code 4, argument 0), which returns the manufacturer byte;
  - read (code 4, argument 0), which returns the device byte.
- R2: A manufacturer byte of 0x00 or 0xFF makes the probe fail, whatever the device byte is.
- R3: Identification table:
  - With manufacturer 0x98, the device codes map to size exponents 0x64→21, 0x6B→22, 0x73→24, 0x75→25, 0xE5→22, 0xE6→23 and 0xEA→21.
  - With manufacturer 0xEC, the device codes map to 0x64→21, 0x73→24, 0x75→25, 0xE3→22, 0xE6→23 and 0xEA→21.
- R4: Any manufacturer/device pair not listed in R3 makes the probe fail. This includes a code that is listed only under the other manufacturer.
- R5: Chips within a floor are probed in ascending index. Probing of that floor ends at the first failure.
- R6: After any failed probe, no further floor is probed. The remaining floors contribute no chips.
- R7: `chip_map` entry i occupies bits [i*EW +: EW] and holds {floor, chip}, with the floor in the upper bits. Entries are filled floor by floor, each floor in chip order. Entries at or beyond `chip_count` read as zero.
- R8: `chip_count` equals the number of successful probes in the scan.
- R9: `size_exp` is the exponent of the last recognised chip. `total_size` equals `chip_count` shifted left by `size_exp`.
- R10: At reset all outputs are zero. At the end of a scan `scan_done` rises and stays high until the next `start`. `none_found` is high exactly when `scan_done` is high and `chip_count` is zero.
- R11: `op_valid` and its `op_code`/`op_arg` stay stable until `op_done` is seen. No operation is requested while `scan_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a scan (accepted in idle or finished state) |
| op_valid | output | 1 | Operation request to the sequencer |
| op_code | output | 3 | Operation kind (0 floor, 1 chip, 2 command, 3 address, 4 read, 5 wait-ready) |
| op_arg | output | 8 | Operation argument byte |
| op_done | input | 1 | Sequencer completes the current operation |
| op_rdata | input | 8 | Byte returned with a completed read |
| scan_done | output | 1 | Scan finished; results valid |
| none_found | output | 1 | Scan finished with no chip found |
| chip_count | output | CNT_W (5) | Number of chips found |
| chip_map | output | FLOORS*CHIPS*EW (64) | Packed {floor, chip} list |
| size_exp | output | EXP_W (5) | Chip size exponent |
| total_size | output | TOT_W (40) | Total capacity in bytes |

## Verification
The bench builds the block with its default 4×4 grid and a 40-bit total. With this grid a fully populated array fills all sixteen map entries. It also drives `chip_count` to its maximum and gives a total of 2^29. The 4×4 grid also makes room for the cross-floor cases:

- a failure in floor 0 that must suppress the populated floors 1 to 3;
- a scan that fills floor 0 completely and then fails partway through floor 1.

Each grid is run with a different sequencer latency, so the operation hold rule is exercised with both immediate and delayed completion.

// File: rtl/flscan_pkg.sv
package flscan_pkg;

    typedef enum logic [2:0] {
        OP_FLOOR = 3'd0,
        OP_CHIP  = 3'd1,
        OP_CMD   = 3'd2,
        OP_ADDR  = 3'd3,
        OP_READ  = 3'd4,
        OP_WAIT  = 3'd5
    } op_e;

    localparam logic [7:0] CMD_RESET  = 8'hFF;
    localparam logic [7:0] CMD_READID = 8'h90;
    localparam logic [7:0] MFR_A      = 8'h98;
    localparam logic [7:0] MFR_B      = 8'hEC;

endpackage

// File: rtl/flscan_idtab.sv
module flscan_idtab #(
    parameter int EXP_W = 5
) (
    input  logic [7:0]       mfr,
    input  logic [7:0]       dev,
    output logic             hit,
    output logic [EXP_W-1:0] exp_o
);
    import flscan_pkg::*;

    logic [EXP_W-1:0] exp_a, exp_b;
    logic             hit_a, hit_b;

    always_comb begin
        hit_a = 1'b1;
        exp_a = '0;
        case (dev)
            8'h64:   exp_a = EXP_W'(21);
            8'h6B:   exp_a = EXP_W'(22);
            8'h73:   exp_a = EXP_W'(24);
            8'h75:   exp_a = EXP_W'(25);
            8'hE5:   exp_a = EXP_W'(22);
            8'hE6:   exp_a = EXP_W'(23);
            8'hEA:   exp_a = EXP_W'(21);
            default: hit_a = 1'b0;
        endcase
    end

    always_comb begin
        hit_b = 1'b1;
        exp_b = '0;
        case (dev)
            8'h64:   exp_b = EXP_W'(21);
            8'h73:   exp_b = EXP_W'(24);
            8'h75:   exp_b = EXP_W'(25);
            8'hE3:   exp_b = EXP_W'(22);
            8'hE6:   exp_b = EXP_W'(23);
            8'hEA:   exp_b = EXP_W'(21);
            default: hit_b = 1'b0;
        endcase
    end

    always_comb begin
        hit   = 1'b0;
        exp_o = '0;
        if (mfr != 8'h00 && mfr != 8'hFF) begin
            if (mfr == MFR_A) begin
                hit   = hit_a;
                exp_o = exp_a;
            end else if (mfr == MFR_B) begin
                hit   = hit_b;
                exp_o = exp_b;
            end
        end
    end

endmodule

// File: rtl/flscan_probe.sv
module flscan_probe #(
    parameter int FW = 2,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [FW-1:0] floor_idx,
    input  logic [CW-1:0] chip_idx,
    input  logic          op_done,
    input  logic [7:0]    op_rdata,
    output logic          op_valid,
    output logic [2:0]    op_code,
    output logic [7:0]    op_arg,
    output logic          done,
    output logic [7:0]    mfr,
    output logic [7:0]    dev
);
    import flscan_pkg::*;

    typedef enum logic [3:0] {
        P_IDLE, P_FLOOR, P_CHIP, P_RST, P_RDY,
        P_IDCMD, P_ADDR, P_RDMFR, P_RDDEV, P_DONE
    } pstate_e;

    pstate_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= P_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            P_IDLE:  if (launch)  nxt = P_FLOOR;
            P_FLOOR: if (op_done) nxt = P_CHIP;
            P_CHIP:  if (op_done) nxt = P_RST;
            P_RST:   if (op_done) nxt = P_RDY;
            P_RDY:   if (op_done) nxt = P_IDCMD;
            P_IDCMD: if (op_done) nxt = P_ADDR;
            P_ADDR:  if (op_done) nxt = P_RDMFR;
            P_RDMFR: if (op_done) nxt = P_RDDEV;
            P_RDDEV: if (op_done) nxt = P_DONE;
            P_DONE:  nxt = P_IDLE;
            default: nxt = P_IDLE;
        endcase
    end

    always_comb begin
        op_valid = 1'b1;
        op_code  = OP_READ;
        op_arg   = 8'h00;
        done     = 1'b0;
        unique case (state)
            P_FLOOR: begin op_code = OP_FLOOR; op_arg = 8'(floor_idx); end
            P_CHIP:  begin op_code = OP_CHIP;  op_arg = 8'(chip_idx);  end
            P_RST:   begin op_code = OP_CMD;   op_arg = CMD_RESET;     end
            P_RDY:   op_code = OP_WAIT;
            P_IDCMD: begin op_code = OP_CMD;   op_arg = CMD_READID;    end
            P_ADDR:  op_code = OP_ADDR;
            P_RDMFR: op_code = OP_READ;
            P_RDDEV: op_code = OP_READ;
            P_DONE:  begin op_valid = 1'b0; done = 1'b1; end
            default: op_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mfr <= 8'h00;
            dev <= 8'h00;
        end else if (op_done) begin
            if (state == P_RDMFR) mfr <= op_rdata;
            if (state == P_RDDEV) dev <= op_rdata;
        end
    end

endmodule

// File: rtl/flscan_map.sv
module flscan_map #(
    parameter int MAXC  = 16,
    parameter int EW    = 4,
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [EW-1:0]     entry,
    output logic [CNT_W-1:0]  count,
    output logic [MAXC*EW-1:0] map_flat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (clr)  count <= '0;
        else if (push) count <= count + 1'b1;
    end

    for (genvar i = 0; i < MAXC; i++) begin : g_slot
        logic [EW-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  slot_q <= '0;
            else if (clr)                                slot_q <= '0;
            else if (push && count == CNT_W'(i))         slot_q <= entry;
        end
        assign map_flat[i*EW +: EW] = slot_q;
    end

endmodule

// File: rtl/flscan_top.sv
module flscan_top #(
    parameter int FLOORS = 4,
    parameter int CHIPS  = 4,
    parameter int EXP_W  = 5,
    parameter int TOT_W  = 40,
    localparam int FW    = (FLOORS > 1) ? $clog2(FLOORS) : 1,
    localparam int CW    = (CHIPS > 1) ? $clog2(CHIPS) : 1,
    localparam int EW    = FW + CW,
    localparam int MAXC  = FLOORS * CHIPS,
    localparam int CNT_W = $clog2(MAXC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                op_valid,
    output logic [2:0]          op_code,
    output logic [7:0]          op_arg,
    input  logic                op_done,
    input  logic [7:0]          op_rdata,
    output logic                scan_done,
    output logic                none_found,
    output logic [CNT_W-1:0]    chip_count,
    output logic [MAXC*EW-1:0]  chip_map,
    output logic [EXP_W-1:0]    size_exp,
    output logic [TOT_W-1:0]    total_size
);

    typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_FINISH} sstate_e;

    sstate_e         state, nxt;
    logic [FW-1:0]   floor_q;
    logic [CW:0]     chip_q;
    logic            halted_q;
    logic [EXP_W-1:0] exp_q;
    logic            done_q;
    logic [TOT_W-1:0] total_q;

    logic            accept, probe_launch, probe_done, push;
    logic            floor_end, last_floor;
    logic [7:0]      p_mfr, p_dev;
    logic            id_hit;
    logic [EXP_W-1:0] id_exp;

    assign accept     = start && (state == S_IDLE || state == S_FINISH);
    assign floor_end  = (chip_q == (CW+1)'(CHIPS));
    assign last_floor = (floor_q == FW'(FLOORS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_LAUNCH;
            S_LAUNCH: begin
                if (halted_q)                     nxt = S_FINISH;
                else if (floor_end && last_floor) nxt = S_FINISH;
                else if (!floor_end)              nxt = S_WAIT;
            end
            S_WAIT:   if (probe_done) nxt = S_LAUNCH;
            S_FINISH: if (start) nxt = S_LAUNCH;
            default:  nxt = S_IDLE;
        endcase
    end

    assign probe_launch = (state == S_LAUNCH) && (nxt == S_WAIT);
    assign push         = (state == S_WAIT) && probe_done && id_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            floor_q  <= '0;
            chip_q   <= '0;
            halted_q <= 1'b0;
            exp_q    <= '0;
            done_q   <= 1'b0;
            total_q  <= '0;
        end else if (accept) begin
            floor_q  <= '0;
            chip_q   <= '0;
            halted_q <= 1'b0;
            exp_q    <= '0;
            done_q   <= 1'b0;
            total_q  <= '0;
        end else begin
            if (state == S_LAUNCH && nxt == S_LAUNCH) begin
                floor_q <= floor_q + 1'b1;
                chip_q  <= '0;
            end
            if (state == S_WAIT && probe_done) begin
                if (id_hit) begin
                    chip_q <= chip_q + 1'b1;
                    exp_q  <= id_exp;
                end else begin
                    halted_q <= 1'b1;
                end
            end
            if (state == S_LAUNCH && nxt == S_FINISH) begin
                done_q  <= 1'b1;
                total_q <= TOT_W'(chip_count) << exp_q;
            end
        end
    end

    flscan_probe #(.FW(FW), .CW(CW)) u_probe (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (probe_launch),
        .floor_idx (floor_q),
        .chip_idx  (chip_q[CW-1:0]),
        .op_done   (op_done),
        .op_rdata  (op_rdata),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .op_arg    (op_arg),
        .done      (probe_done),
        .mfr       (p_mfr),
        .dev       (p_dev)
    );

    flscan_idtab #(.EXP_W(EXP_W)) u_idtab (
        .mfr   (p_mfr),
        .dev   (p_dev),
        .hit   (id_hit),
        .exp_o (id_exp)
    );

    flscan_map #(.MAXC(MAXC), .EW(EW), .CNT_W(CNT_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .push     (push),
        .entry    ({floor_q, chip_q[CW-1:0]}),
        .count    (chip_count),
        .map_flat (chip_map)
    );

    assign scan_done  = done_q;
    assign none_found = done_q && (chip_count == '0);
    assign size_exp   = exp_q;
    assign total_size = total_q;

endmodule

// File: rtl/flscan_chk.sv
module flscan_chk #(
    parameter int CNT_W = 5,
    parameter int EXP_W = 5,
    parameter int TOT_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [7:0]       op_arg,
    input logic             op_done,
    input logic             scan_done,
    input logic             none_found,
    input logic [CNT_W-1:0] chip_count,
    input logic [EXP_W-1:0] size_exp,
    input logic [TOT_W-1:0] total_size
);

    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_done) |=> (op_valid && $stable(op_code) && $stable(op_arg)));

    p_idle_when_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !scan_done);

    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_code <= 3'd5));

    p_count_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (chip_count >= $past(chip_count)));

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && !start) |=> scan_done);

    p_none_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (none_found == (chip_count == '0)));

    p_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (total_size == (TOT_W'(chip_count) << size_exp)));

endmodule

bind flscan_top flscan_chk #(.CNT_W(CNT_W), .EXP_W(EXP_W), .TOT_W(TOT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_arg     (op_arg),
    .op_done    (op_done),
    .scan_done  (scan_done),
    .none_found (none_found),
    .chip_count (chip_count),
    .size_exp   (size_exp),
    .total_size (total_size)
);

// File: tb/flscan_top_bench.sv
module flscan_top_bench;

    localparam int NF = 4;
    localparam int NC = 4;
    localparam int EW = 4;
    localparam int MAXC = NF * NC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [7:0]  op_arg;
    logic        op_done = 1'b0;
    logic [7:0]  op_rdata = 8'h00;
    logic        scan_done, none_found;
    logic [4:0]  chip_count;
    logic [MAXC*EW-1:0] chip_map;
    logic [4:0]  size_exp;
    logic [39:0] total_size;

    always #4 clk = ~clk;

    flscan_top u_flscan_top (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_valid(op_valid), .op_code(op_code), .op_arg(op_arg),
        .op_done(op_done), .op_rdata(op_rdata),
        .scan_done(scan_done), .none_found(none_found),
        .chip_count(chip_count), .chip_map(chip_map),
        .size_exp(size_exp), .total_size(total_size)
    );

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] g_mfr [NF][NC];
    logic [7:0] g_dev [NF][NC];

    int exp_ops [$];
    int e_count, e_exp;
    int e_map [MAXC];
    int lat = 0;

    int cur_f = 0, cur_c = 0, rd_idx = 0;
    bit busy = 0;
    int waitc = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int ref_exp(input logic [7:0] m, input logic [7:0] d);
        if (m == 8'h98) begin
            if (d == 8'h64 || d == 8'hEA) return 21;
            if (d == 8'h6B || d == 8'hE5) return 22;
            if (d == 8'hE6) return 23;
            if (d == 8'h73) return 24;
            if (d == 8'h75) return 25;
        end
        if (m == 8'hEC) begin
            if (d == 8'h64 || d == 8'hEA) return 21;
            if (d == 8'hE3) return 22;
            if (d == 8'hE6) return 23;
            if (d == 8'h73) return 24;
            if (d == 8'h75) return 25;
        end
        return -1;
    endfunction

    task automatic build_expect();
        bit stopped = 0;
        exp_ops.delete();
        e_count = 0;
        e_exp = 0;
        for (int i = 0; i < MAXC; i++) e_map[i] = 0;
        for (int f = 0; f < NF; f++) begin
            if (!stopped) begin
                for (int c = 0; c < NC; c++) begin
                    if (!stopped) begin
                        int r;
                        exp_ops.push_back(0*256 + f);
                        exp_ops.push_back(1*256 + c);
                        exp_ops.push_back(2*256 + 8'hFF);
                        exp_ops.push_back(5*256);
                        exp_ops.push_back(2*256 + 8'h90);
                        exp_ops.push_back(3*256);
                        exp_ops.push_back(4*256);
                        exp_ops.push_back(4*256);
                        r = ref_exp(g_mfr[f][c], g_dev[f][c]);
                        if (r < 0) stopped = 1;
                        else begin
                            e_map[e_count] = f * NC + c;
                            e_count++;
                            e_exp = r;
                        end
                    end
                end
            end
        end
    endtask

    // Sequencer model: compares each requested operation (R1, R5, R6) against the expected stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (op_done) begin
                op_done = 1'b0;
                busy = 0;
            end else if (op_valid) begin
                if (!busy) begin
                    int want;
                    busy = 1;
                    waitc = 0;
                    if (exp_ops.size() == 0) begin
                        check(0, "R6 unexpected op", {op_code, op_arg}, 0);
                    end else begin
                        want = exp_ops.pop_front();
                        check((int'(op_code) * 256 + int'(op_arg)) == want, "R1/R5 op order",
                              int'(op_code) * 256 + int'(op_arg), want);
                    end
                    case (op_code)
                        3'd0: cur_f = int'(op_arg) % NF;
                        3'd1: cur_c = int'(op_arg) % NC;
                        3'd2: rd_idx = 0;
                        default: ;
                    endcase
                end
                if (waitc >= lat) begin
                    if (op_code == 3'd4) begin
                        op_rdata = (rd_idx == 0) ? g_mfr[cur_f][cur_c] : g_dev[cur_f][cur_c];
                        rd_idx++;
                    end
                    op_done = 1'b1;
                end else begin
                    waitc++;
                end
            end
        end
    end

    task automatic run_scan(input string name);
        int cyc = 0;
        build_expect();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!scan_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check(scan_done, "R10 watchdog", cyc, 0);
        check(exp_ops.size() == 0, "R6 ops left unissued", exp_ops.size(), 0);
        check(chip_count == e_count, "R8 count", chip_count, e_count);
        if (e_count > 0) begin
            check(size_exp == e_exp, "R9 exponent", size_exp, e_exp);
        end
        check(total_size == (40'(e_count) << ((e_count > 0) ? e_exp : 0)), "R9 total",
              total_size, 40'(e_count) << ((e_count > 0) ? e_exp : 0));
        check(none_found == (e_count == 0), "R10 none_found", none_found, e_count == 0);
        for (int i = 0; i < MAXC; i++) begin
            int want = (i < e_count) ? e_map[i] : 0;
            check(int'(chip_map[i*EW +: EW]) == want, "R7 map entry",
                  chip_map[i*EW +: EW], want);
        end
        repeat (3) @(negedge clk);
        check(scan_done == 1'b1, "R10 done held", scan_done, 1);
        $display("scan %s done: %0d chips", name, chip_count);
    endtask

    task automatic fill(input logic [7:0] m, input logic [7:0] d);
        for (int f = 0; f < NF; f++)
            for (int c = 0; c < NC; c++) begin
                g_mfr[f][c] = m;
                g_dev[f][c] = d;
            end
    endtask

    initial begin
        fill(8'hFF, 8'hFF);
        repeat (3) @(negedge clk);
        check(scan_done == 0 && chip_count == 0 && total_size == 0 && op_valid == 0,
              "R10 reset state", {scan_done, chip_count}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(scan_done == 0 && size_exp == 0 && chip_map == 0, "R10 reset outputs",
              chip_map, 0);

        // R3 R5 R6: floor 0 stops at chip 2; populated floors 1..3 must not be probed
        lat = 0;
        fill(8'h98, 8'hE6);
        g_mfr[0][2] = 8'hFF;
        run_scan("stop-in-floor0");

        // R3 R7 R8: fully populated grid
        lat = 2;
        fill(8'hEC, 8'h75);
        run_scan("full");

        // R2: zero manufacturer at the first position
        lat = 1;
        fill(8'h98, 8'h73);
        g_mfr[0][0] = 8'h00;
        run_scan("zero-mfr");

        // R4 R9: floor 0 full, then 0x6B under the second vendor is not listed
        lat = 3;
        fill(8'h98, 8'h6B);
        g_mfr[1][0] = 8'hEC; g_dev[1][0] = 8'h64;
        g_mfr[1][1] = 8'hEC; g_dev[1][1] = 8'h6B;
        run_scan("cross-vendor");

        // R2: 0xFF manufacturer with an otherwise valid device code on chip 1
        lat = 0;
        fill(8'hEC, 8'hE3);
        g_mfr[0][1] = 8'hFF; g_dev[0][1] = 8'hE3;
        run_scan("ff-mfr");

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule